// File: doc/BRIEF.md
# Dual-Side Prioritized Sound Interrupt Controller

This block gathers eleven interrupt events of a sound subsystem and presents them to two processors: a slave processor that runs the sound firmware, and the main host processor. Each side keeps its own enable register and pending register. A write-one-to-clear register on each side removes pending bits. Hardware event pulses set pending bits on both sides at once. A sample tick input marks the sample-done source on both sides.

The slave side gets a vector of active sources and a 3-bit level code. The code is formed from three shared level-select registers, each read at the position of the lowest-numbered active source. The host side gets a single level-sensitive request line. Software reaches every register through one write port and one combinational read port. The reset input is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `snd_irq_hub`

## Requirements
- R1: A write to either enable register (slave address 0, host address 3) stores only data bits 10:0. Reading that register back returns zeros in bits 15:11.
- R2: `slv_vec_o` bit i is 1 exactly when slave enable bit i and slave pending bit i are both 1.
- R3: When several slave sources are active, the level code is taken from the one with the lowest bit index.
- R4: Bit 0 of `slv_level_o` is level register 0 (address 6) at the winning index. Bit 1 is level register 1 (address 7) at that index. Bit 2 is level register 2 (address 8) at that index.
- R5: When the winning index is 8, 9 or 10, the level lookup uses bit position 7 of the three level registers.
- R6: A write to a pending register (slave address 1, host address 4) sets pending bit 5 when data bit 5 is 1. The write changes no other pending bit.
- R7: A write to a clear register (slave address 2, host address 5) clears every pending bit whose data bit is 1. Clear registers read back as 0.
- R8: A cycle with `sample_tick_i` high sets pending bit 10 on both the slave side and the host side.
- R9: `host_irq_o` is 1 exactly while some host source is both enabled and pending.
- R10: An event pulse on `evt_i` sets the matching pending bit on both sides. This holds even when a clear write names the same bit in the same cycle.
- R11: `slv_level_o` is 0 when no slave source is active.
- R12: After reset, all enable, pending and level registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| evt_i | input | 11 | Event pulses, one bit per source, setting pending on both sides |
| sample_tick_i | input | 1 | Sample tick, sets source 10 pending on both sides |
| slv_vec_o | output | 11 | Slave active-source vector |
| slv_level_o | output | 3 | Slave level code of the winning source |
| host_irq_o | output | 1 | Host interrupt request line |

## Verification
The level code is exercised in three cases: a single active source, two active sources whose level bits differ (this separates a lowest-index winner from a highest-index one), and a winner above index 7 (this shows whether the lookup clamps to position 7). Writes of all ones are made to the enable and pending registers. The all-ones enable write checks the width mask. The all-ones pending write checks that software can set only bit 5. A same-cycle event and clear checks which of the two wins. Sample ticks, and host enable turned on and off, drive the request line in both directions.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  typedef enum logic [3:0] {
    A_SEN  = 4'd0,
    A_SPD  = 4'd1,
    A_SCLR = 4'd2,
    A_HEN  = 4'd3,
    A_HPD  = 4'd4,
    A_HCLR = 4'd5,
    A_LV0  = 4'd6,
    A_LV1  = 4'd7,
    A_LV2  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NSRC     = 11,
  parameter int DW       = 16,
  parameter int SW_BIT   = 5,
  parameter int TICK_BIT = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_reg,
  input  logic            wr_pend_reg,
  input  logic            wr_clr_reg,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] evt,
  input  logic            tick,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] active
);
  localparam logic [NSRC-1:0] SW_M   = NSRC'(1) << SW_BIT;
  localparam logic [NSRC-1:0] TICK_M = NSRC'(1) << TICK_BIT;

  logic [NSRC-1:0] en_d, pend_d, clr_m, sw_m, tk_m;
  logic            en_ce, pend_ce;

  always_comb begin
    en_ce   = wr_en_reg;
    en_d    = wr_data[NSRC-1:0];
    clr_m   = wr_clr_reg ? wr_data[NSRC-1:0] : '0;
    sw_m    = (wr_pend_reg && wr_data[SW_BIT]) ? SW_M : '0;
    tk_m    = tick ? TICK_M : '0;
    pend_ce = wr_pend_reg | wr_clr_reg | (|evt) | tick;
    pend_d  = (pend_q & ~clr_m) | evt | sw_m | tk_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  assign active = en_q & pend_q;

  // R6: a pending write alone touches only the software bit
  p_sw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend_reg && !wr_clr_reg && !tick && evt == '0)
    |=> pend_q == ($past(pend_q) | ($past(wr_data[SW_BIT]) ? SW_M : '0)));

  // R7: a clear write alone drops exactly the named bits
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr_reg && !wr_pend_reg && !tick && evt == '0)
    |=> pend_q == ($past(pend_q) & ~$past(wr_data[NSRC-1:0])));

  // R10: event pulses always land, whatever else happens
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R8: tick marks sample-done
  p_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend_q[TICK_BIT]);
endmodule

// File: rtl/prio_level.sv
module prio_level #(
  parameter int NSRC = 11,
  parameter int CAP  = 7,
  localparam int LVW = CAP + 1,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] active,
  input  logic [LVW-1:0]  lv0,
  input  logic [LVW-1:0]  lv1,
  input  logic [LVW-1:0]  lv2,
  output logic [2:0]      level
);
  logic [IW-1:0] win;
  logic [IW-1:0] pos;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) win = IW'(i);
    end
    pos = (win > IW'(CAP)) ? IW'(CAP) : win;
    if (active == '0) level = 3'd0;
    else              level = {lv2[pos], lv1[pos], lv0[pos]};
  end

  // R11: idle gives level zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (level == 3'd0));

  // R3: source 0 active always owns the level
  p_src0_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active[0] |-> (level == {lv2[0], lv1[0], lv0[0]}));
endmodule

// File: rtl/snd_irq_hub.sv
module snd_irq_hub #(
  parameter int NSRC     = 11,
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int SW_BIT   = 5,
  parameter int TICK_BIT = 10,
  parameter int CAP      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic [NSRC-1:0] evt_i,
  input  logic            sample_tick_i,
  output logic [NSRC-1:0] slv_vec_o,
  output logic [2:0]      slv_level_o,
  output logic            host_irq_o
);
  import snd_irq_pkg::*;
  localparam int LVW = CAP + 1;

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [NSRC-1:0] s_en, s_pd, s_act, h_en, h_pd, h_act;
  logic [LVW-1:0]  lv_q [3];
  logic [LVW-1:0]  lv_d;
  logic [2:0]      lv_ce;

  function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
    return wr_en_i && (a == AW'(r));
  endfunction

  irq_bank #(.NSRC(NSRC), .DW(DW), .SW_BIT(SW_BIT), .TICK_BIT(TICK_BIT)) u_slv (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en_reg(hit(wr_addr_i, A_SEN)), .wr_pend_reg(hit(wr_addr_i, A_SPD)),
    .wr_clr_reg(hit(wr_addr_i, A_SCLR)), .wr_data(wr_data_i),
    .evt(evt_i), .tick(sample_tick_i),
    .en_q(s_en), .pend_q(s_pd), .active(s_act));

  irq_bank #(.NSRC(NSRC), .DW(DW), .SW_BIT(SW_BIT), .TICK_BIT(TICK_BIT)) u_host (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en_reg(hit(wr_addr_i, A_HEN)), .wr_pend_reg(hit(wr_addr_i, A_HPD)),
    .wr_clr_reg(hit(wr_addr_i, A_HCLR)), .wr_data(wr_data_i),
    .evt(evt_i), .tick(sample_tick_i),
    .en_q(h_en), .pend_q(h_pd), .active(h_act));

  always_comb begin
    lv_d  = wr_data_i[LVW-1:0];
    lv_ce = {hit(wr_addr_i, A_LV2), hit(wr_addr_i, A_LV1), hit(wr_addr_i, A_LV0)};
  end

  for (genvar g = 0; g < 3; g++) begin : g_lv
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)     lv_q[g] <= '0;
      else if (lv_ce[g]) lv_q[g] <= lv_d;
    end
  end

  prio_level #(.NSRC(NSRC), .CAP(CAP)) u_prio (
    .clk(clk), .rst_n(rst_q_n), .active(s_act),
    .lv0(lv_q[0]), .lv1(lv_q[1]), .lv2(lv_q[2]), .level(slv_level_o));

  assign slv_vec_o  = s_act;
  assign host_irq_o = |h_act;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(A_SEN): rd_data_o = DW'(s_en);
      AW'(A_SPD): rd_data_o = DW'(s_pd);
      AW'(A_HEN): rd_data_o = DW'(h_en);
      AW'(A_HPD): rd_data_o = DW'(h_pd);
      AW'(A_LV0): rd_data_o = DW'(lv_q[0]);
      AW'(A_LV1): rd_data_o = DW'(lv_q[1]);
      AW'(A_LV2): rd_data_o = DW'(lv_q[2]);
      default:    rd_data_o = '0;
    endcase
  end

  // R9: host line follows host enable and pending state
  p_host_line_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_irq_o |-> ((h_en & h_pd) != '0));
endmodule

// File: tb/snd_irq_hub_tb.sv
module snd_irq_hub_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic [10:0] evt_i = '0;
  logic        sample_tick_i = 1'b0;
  logic [10:0] slv_vec_o;
  logic [2:0]  slv_level_o;
  logic        host_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  snd_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .evt_i(evt_i), .sample_tick_i(sample_tick_i), .slv_vec_o(slv_vec_o),
    .slv_level_o(slv_level_o), .host_irq_o(host_irq_o));

  typedef struct {
    logic [10:0] vec;
    logic [2:0]  lvl;
    logic        host;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  logic [10:0] m_sen = '0, m_spd = '0, m_hen = '0, m_hpd = '0;
  logic [7:0]  m_lv0 = '0, m_lv1 = '0, m_lv2 = '0;

  function automatic logic [2:0] calc_lvl(input logic [10:0] act);
    int p;
    p = -1;
    for (int i = 10; i >= 0; i--) if (act[i]) p = i;
    if (p < 0) return 3'd0;
    if (p > 7) p = 7;
    return {m_lv2[p], m_lv1[p], m_lv0[p]};
  endfunction

  function automatic logic [15:0] calc_rd(input logic [3:0] a);
    case (a)
      4'd0: return {5'b0, m_sen};
      4'd1: return {5'b0, m_spd};
      4'd3: return {5'b0, m_hen};
      4'd4: return {5'b0, m_hpd};
      4'd6: return {8'b0, m_lv0};
      4'd7: return {8'b0, m_lv1};
      4'd8: return {8'b0, m_lv2};
      default: return 16'd0;
    endcase
  endfunction

  task automatic step(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                      input logic [10:0] ev, input logic tk, input logic [3:0] ra,
                      input string tag);
    logic [10:0] sclr, hclr, ssw, hsw, tkm;
    exp_t e;
    @(negedge clk);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    evt_i = ev; sample_tick_i = tk; rd_addr_i = ra;
    sclr = '0; hclr = '0; ssw = '0; hsw = '0;
    tkm = tk ? 11'h400 : 11'h000;
    if (we) begin
      case (wa)
        4'd0: m_sen = wd[10:0];
        4'd1: ssw = wd[5] ? 11'h020 : 11'h000;
        4'd2: sclr = wd[10:0];
        4'd3: m_hen = wd[10:0];
        4'd4: hsw = wd[5] ? 11'h020 : 11'h000;
        4'd5: hclr = wd[10:0];
        4'd6: m_lv0 = wd[7:0];
        4'd7: m_lv1 = wd[7:0];
        4'd8: m_lv2 = wd[7:0];
        default: ;
      endcase
    end
    m_spd = (m_spd & ~sclr) | ev | ssw | tkm;
    m_hpd = (m_hpd & ~hclr) | ev | hsw | tkm;
    e.vec  = m_sen & m_spd;
    e.lvl  = calc_lvl(m_sen & m_spd);
    e.host = |(m_hen & m_hpd);
    e.rd   = calc_rd(ra);
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (slv_vec_o !== e.vec || slv_level_o !== e.lvl ||
          host_irq_o !== e.host || rd_data_o !== e.rd) begin
        failures++;
        $display("FAIL %s: vec=%h lvl=%0d host=%b rd=%h expected vec=%h lvl=%0d host=%b rd=%h",
                 e.tag, slv_vec_o, slv_level_o, host_irq_o, rd_data_o,
                 e.vec, e.lvl, e.host, e.rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (slv_vec_o !== 0 || slv_level_o !== 0 || host_irq_o !== 0 || rd_data_o !== 0) begin
      failures++;
      $display("FAIL R12: vec=%h lvl=%0d host=%b rd=%h expected all zero",
               slv_vec_o, slv_level_o, host_irq_o, rd_data_o);
    end
    step(0, 4'd0, 16'h0, 11'h0, 0, 4'd8, "R12 level2 reset");
    step(1, 4'd0, 16'hFFFF, 11'h0, 0, 4'd0, "R1 slave enable mask");
    step(1, 4'd3, 16'hF800, 11'h0, 0, 4'd3, "R1 host enable upper bits dropped");
    step(0, 4'd0, 16'h0, 11'h008, 0, 4'd1, "R2 single source, zero level regs");
    step(1, 4'd6, 16'h0008, 11'h0, 0, 4'd6, "R4 level0 bit");
    step(1, 4'd8, 16'h0008, 11'h0, 0, 4'd8, "R4 level2 bit");
    step(1, 4'd7, 16'h0002, 11'h0, 0, 4'd7, "R4 level1 set at index 1 only");
    step(0, 4'd0, 16'h0, 11'h002, 0, 4'd1, "R3 lowest index wins");
    step(1, 4'd2, 16'h0002, 11'h0, 0, 4'd1, "R7 clear bit 1, bit 3 wins again");
    step(1, 4'd2, 16'h0008, 11'h0, 0, 4'd2, "R11 nothing active, level zero");
    step(1, 4'd7, 16'h0082, 11'h0, 0, 4'd7, "R5 level1 bit 7");
    step(0, 4'd0, 16'h0, 11'h200, 0, 4'd1, "R5 index 9 uses position 7");
    step(1, 4'd2, 16'h0200, 11'h0, 0, 4'd1, "R7 clear index 9");
    step(1, 4'd1, 16'hFFDF, 11'h0, 0, 4'd1, "R6 pending write without bit 5");
    step(1, 4'd1, 16'hFFFF, 11'h0, 0, 4'd1, "R6 pending write sets only bit 5");
    step(1, 4'd2, 16'h0020, 11'h0, 0, 4'd1, "R7 clear software bit");
    step(0, 4'd0, 16'h0, 11'h0, 1, 4'd4, "R8 tick host pending, host disabled");
    step(1, 4'd3, 16'h0400, 11'h0, 0, 4'd1, "R9 host enable raises line");
    step(1, 4'd5, 16'h0400, 11'h0, 0, 4'd4, "R9 host clear drops line");
    step(1, 4'd5, 16'h0400, 11'h0, 1, 4'd4, "R10 tick beats host clear");
    step(1, 4'd2, 16'h0401, 11'h001, 0, 4'd1, "R10 event beats slave clear");
    step(1, 4'd3, 16'h0000, 11'h0, 0, 4'd3, "R9 host disable drops line");
    step(1, 4'd4, 16'h0020, 11'h0, 0, 4'd4, "R6 host software bit");
    step(1, 4'd3, 16'h0020, 11'h0, 0, 4'd2, "R9 host line from software bit");
    step(0, 4'd0, 16'h0, 11'h0, 0, 4'd0, "R2 idle hold");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule